// File: doc/BRIEF.md
# Dual-Line Serial Converter Readout Controller

This block sits on the host side of an eight-channel simultaneous-sampling converter that has been strapped for serial output. It watches the converter's conversion-busy signal. Once a conversion has ended, it pulls chip select low and drives a divided serial clock. It then shifts in the sixteen-bit results, MSB first, from one or two serial data lines. Each completed result comes out on a simple valid/data port with a channel tag.

In two-line mode, line A delivers channels 0 to 3 while line B delivers channels 4 to 7 on the same clock edges, so a frame takes 64 serial clocks. The line-B words are held in a small buffer and released after the line-A words, so the host always sees channels in ascending order. In single-line mode, line A delivers all eight results back to back over 128 serial clocks.

The converter raises a first-data flag while channel 0 is on line A. The controller checks this flag at the first sample of every frame. A frame that starts out of alignment is abandoned, so misaligned words are never delivered.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, csN and sclkOut are high and outValid is low.
- R2: A frame starts only after busyIn has been seen high and then low. While busyIn stays high, csN stays high.
- R3: In two-line mode (twoLineMode=1), a frame has exactly 64 falling edges of sclkOut while csN is low. Line A yields channels 0..3 and line B yields channels 4..7, each word MSB first.
- R4: In single-line mode (twoLineMode=0), a frame has exactly 128 falling edges of sclkOut while csN is low. All eight words come from line A, in channel order.
- R5: Each frame emits one-cycle outValid pulses with outChan equal to 0,1,...,7 in that order, and outData equal to that channel's result.
- R6: Input bits are sampled on the falling edge of sclkOut. The converter presents the MSB when csN falls and moves to the next bit on each rising edge of sclkOut.
- R7: If firstData is low at the first sample of a frame, csN returns high without any sclkOut falling edge and no word is emitted. A later frame then proceeds normally.
- R8: A busyIn falling edge during an active frame does not start a new frame or add words. Exactly 8 words are emitted per frame.
- R9: The mode is captured when csN falls. Changing twoLineMode during a frame has no effect on that frame.
- R10: sclkOut is high whenever csN is high, and sclkOut changes only while a frame is active. Each sclkOut phase lasts HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busyIn | input | 1 | Conversion-busy from the converter |
| twoLineMode | input | 1 | 1: two data lines, 0: line A only |
| firstData | input | 1 | Converter flag, high while channel 0 is on line A |
| serA | input | 1 | Serial data line A |
| serB | input | 1 | Serial data line B |
| csN | output | 1 | Active-low chip select framing the read |
| sclkOut | output | 1 | Serial clock, idles high |
| outValid | output | 1 | One-cycle strobe for a received word |
| outData | output | 16 | Received result |
| outChan | output | 3 | Channel tag of outData |

## Verification
A wrong bit counter or a wrong mode latch shows at once as the wrong number of sclkOut falling edges within the frame. It also shows as words that carry shifted data, which appear at the first outValid, sixteen serial clocks after csN falls. Line-B buffer faults show only after csN rises, when channels 4..7 are released. A skipped alignment check shows as words emitted after a frame that should have been abandoned, within one frame time.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int WORD_W  = 16;
  localparam int NUM_CH  = 8;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int HALF_CH = NUM_CH / 2;
  localparam int HALF_W  = $clog2(HALF_CH);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int CNT_W   = $clog2(NUM_CH * WORD_W) + 1;

  typedef struct packed {
    logic              sample;
    logic              wordDone;
    logic [CH_W-1:0]   wordIdx;
    logic              drain;
    logic [HALF_W-1:0] drainIdx;
    logic              dual;
  } strobe_t;
endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    busyIn,
  input  logic    twoLineMode,
  input  logic    firstData,
  output logic    csN,
  output logic    sclkOut,
  output strobe_t stb
);
  localparam int DIV_W = $clog2(HALF_DIV) + 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] BITS_DUAL   = CNT_W'(HALF_CH * WORD_W);
  localparam logic [CNT_W-1:0] BITS_SINGLE = CNT_W'(NUM_CH * WORD_W);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_DRAIN} state_t;

  state_t            state;
  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic [HALF_W-1:0] drainCnt;
  logic              busyQ;
  logic              dualQ;
  logic              divEnd;
  logic              sampling;
  logic              abortNow;
  logic [CNT_W-1:0]  frameBits;

  assign divEnd    = (divCnt == DIV_LAST);
  assign frameBits = dualQ ? BITS_DUAL : BITS_SINGLE;
  assign sampling  = ((state == S_SETUP) || (state == S_HIGH)) && divEnd;
  assign abortNow  = sampling && (bitCnt == '0) && !firstData;

  always_comb begin
    stb.sample   = sampling && !abortNow;
    stb.wordDone = stb.sample && (bitCnt[BIT_W-1:0] == {BIT_W{1'b1}});
    stb.wordIdx  = bitCnt[BIT_W +: CH_W];
    stb.drain    = (state == S_DRAIN);
    stb.drainIdx = drainCnt;
    stb.dual     = dualQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      csN      <= 1'b1;
      sclkOut  <= 1'b1;
      divCnt   <= '0;
      bitCnt   <= '0;
      drainCnt <= '0;
      busyQ    <= 1'b0;
      dualQ    <= 1'b0;
    end else begin
      busyQ <= busyIn;
      unique case (state)
        S_IDLE: begin
          if (busyQ && !busyIn) begin
            state  <= S_SETUP;
            csN    <= 1'b0;
            divCnt <= '0;
            bitCnt <= '0;
            dualQ  <= twoLineMode;
          end
        end
        S_SETUP, S_HIGH: begin
          if (divEnd) begin
            divCnt <= '0;
            if (abortNow) begin
              state <= S_IDLE;
              csN   <= 1'b1;
            end else begin
              sclkOut <= 1'b0;
              bitCnt  <= bitCnt + 1'b1;
              state   <= S_LOW;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        S_LOW: begin
          if (divEnd) begin
            divCnt  <= '0;
            sclkOut <= 1'b1;
            if (bitCnt == frameBits) begin
              csN      <= 1'b1;
              drainCnt <= '0;
              state    <= dualQ ? S_DRAIN : S_IDLE;
            end else begin
              state <= S_HIGH;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        S_DRAIN: begin
          drainCnt <= drainCnt + 1'b1;
          if (drainCnt == HALF_W'(HALF_CH - 1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_dpath.sv
module adc_rd_dpath
  import adc_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serA,
  input  logic              serB,
  input  strobe_t           stb,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  output logic [CH_W-1:0]   outChan
);
  logic [WORD_W-1:0] shA, shB;
  logic [WORD_W-1:0] nextA, nextB;
  logic [WORD_W-1:0] bufB [HALF_CH];

  assign nextA = {shA[WORD_W-2:0], serA};
  assign nextB = {shB[WORD_W-2:0], serB};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shA <= '0;
      shB <= '0;
    end else if (stb.sample) begin
      shA <= nextA;
      shB <= nextB;
    end
  end

  for (genvar g = 0; g < HALF_CH; g++) begin : g_bufB
    logic wrEn;
    assign wrEn = stb.wordDone && stb.dual && (stb.wordIdx[HALF_W-1:0] == HALF_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN)     bufB[g] <= '0;
      else if (wrEn) bufB[g] <= nextB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outChan  <= '0;
    end else if (stb.wordDone) begin
      outValid <= 1'b1;
      outData  <= nextA;
      outChan  <= stb.wordIdx;
    end else if (stb.drain) begin
      outValid <= 1'b1;
      outData  <= bufB[stb.drainIdx];
      outChan  <= {1'b1, stb.drainIdx};
    end else begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busyIn,
  input  logic              twoLineMode,
  input  logic              firstData,
  input  logic              serA,
  input  logic              serB,
  output logic              csN,
  output logic              sclkOut,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  output logic [CH_W-1:0]   outChan
);
  strobe_t stb;

  adc_rd_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .twoLineMode(twoLineMode),
    .firstData(firstData), .csN(csN), .sclkOut(sclkOut), .stb(stb)
  );

  adc_rd_dpath u_dpath (
    .clk(clk), .rstN(rstN), .serA(serA), .serB(serB), .stb(stb),
    .outValid(outValid), .outData(outData), .outChan(outChan)
  );
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk
  import adc_rd_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            busyIn,
  input logic            csN,
  input logic            sclkOut,
  input logic            outValid,
  input logic [CH_W-1:0] outChan
);
  logic [CH_W:0] chanCnt;
  logic          csQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanCnt <= '0;
      csQ     <= 1'b1;
    end else begin
      csQ <= csN;
      if (csQ && !csN)   chanCnt <= '0;
      else if (outValid) chanCnt <= chanCnt + 1'b1;
    end
  end

  assert_idle_clock_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclkOut);

  assert_clock_in_frame_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOut != $past(sclkOut)) |-> !$past(csN));

  assert_start_after_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (!$past(busyIn) && $past(busyIn, 2)));

  assert_chan_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outChan == chanCnt[CH_W-1:0]));

  assert_word_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (chanCnt < (CH_W+1)'(NUM_CH)));
endmodule

bind adc_serial_reader adc_serial_reader_chk u_chk (
  .clk(clk), .rstN(rstN), .busyIn(busyIn), .csN(csN), .sclkOut(sclkOut),
  .outValid(outValid), .outChan(outChan)
);

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;
  localparam int HALF_DIV = 2;

  typedef struct packed {
    logic        dual;
    logic [15:0] seed;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b1, 16'hA5C3}, '{1'b0, 16'h0001}, '{1'b1, 16'hFFFF}, '{1'b0, 16'h8000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busyIn = 1'b0, twoLineMode = 1'b0, firstData = 1'b0;
  logic serA = 1'b0, serB = 1'b0;
  logic csN, sclkOut, outValid;
  logic [15:0] outData;
  logic [2:0] outChan;

  int checks = 0, errors = 0;
  int gotN = 0, fallCnt = 0;
  logic [2:0]  gotC [16];
  logic [15:0] gotD [16];
  logic [15:0] modelWords [8];
  logic curDual = 1'b0, fdEnable = 1'b1;
  int bitPtr = 0, wordPtr = 0;
  logic prevS = 1'b1, prevM = 1'b1;

  always #4 clk = ~clk;

  adc_serial_reader #(.HALF_DIV(HALF_DIV)) u_adc_serial_reader (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .twoLineMode(twoLineMode),
    .firstData(firstData), .serA(serA), .serB(serB), .csN(csN),
    .sclkOut(sclkOut), .outValid(outValid), .outData(outData), .outChan(outChan)
  );

  function automatic logic [15:0] wordOf(input logic [15:0] s, input int ch);
    return s ^ 16'(ch * 32'h1357) ^ {4'(ch), 12'h0};
  endfunction

  // converter model: MSB at chip-select fall, next bit on each sclk rise
  always @(negedge clk) begin
    if (csN) begin
      bitPtr = 0; wordPtr = 0; prevS = 1'b1;
      serA = 1'b0; serB = 1'b0; firstData = 1'b0;
    end else begin
      if (!prevS && sclkOut) begin
        bitPtr++;
        if (bitPtr == 16) begin bitPtr = 0; wordPtr++; end
      end
      prevS = sclkOut;
      serA = (wordPtr < 8) ? modelWords[wordPtr][15-bitPtr] : 1'b0;
      serB = (curDual && wordPtr < 4) ? modelWords[wordPtr+4][15-bitPtr] : 1'b0;
      firstData = fdEnable && (wordPtr == 0);
    end
  end

  always @(negedge clk) begin
    if (outValid && gotN < 16) begin
      gotC[gotN] = outChan; gotD[gotN] = outData; gotN++;
    end
    if (!csN && prevM && !sclkOut) fallCnt++;
    prevM = sclkOut;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runFrame(input logic dual, input logic [15:0] seed, input bit fdOk, input bit disturb);
    int expWords, expFalls;
    for (int c = 0; c < 8; c++) modelWords[c] = wordOf(seed, c);
    curDual = dual; fdEnable = fdOk; twoLineMode = dual;
    @(negedge clk); gotN = 0; fallCnt = 0;
    busyIn = 1'b1;
    repeat (3) @(negedge clk);
    busyIn = 1'b0;
    for (int t = 0; t < 20 && csN; t++) @(negedge clk);
    if (disturb) begin
      repeat (40) @(negedge clk);
      busyIn = 1'b1; twoLineMode = ~dual;
      repeat (3) @(negedge clk);
      busyIn = 1'b0;
    end
    for (int t = 0; t < 2000 && !csN; t++) @(negedge clk);
    repeat (12) @(negedge clk);
    twoLineMode = dual;
    expWords = fdOk ? 8 : 0;
    expFalls = fdOk ? (dual ? 64 : 128) : 0;
    chk(gotN == expWords, fdOk ? "R5/R8 word count" : "R7 no words on misalignment", gotN, expWords);
    chk(fallCnt == expFalls, dual ? "R3/R10 falling edges" : "R4/R10 falling edges", fallCnt, expFalls);
    chk(csN && sclkOut, "R10 idle lines after frame", {csN, sclkOut}, 2'b11);
    for (int i = 0; i < gotN && i < 8; i++) begin
      chk(gotC[i] == 3'(i), "R5 channel tag", gotC[i], i);
      chk(gotD[i] == wordOf(seed, i), dual ? "R3/R6 data" : "R4/R6 data", gotD[i], wordOf(seed, i));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(csN && sclkOut && !outValid, "R1 reset outputs", {csN, sclkOut, outValid}, 3'b110);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(csN && sclkOut && !outValid, "R1 after reset release", {csN, sclkOut, outValid}, 3'b110);
    busyIn = 1'b1;
    begin
      bit stayed = 1'b1;
      for (int t = 0; t < 40; t++) begin @(negedge clk); if (!csN) stayed = 1'b0; end
      chk(stayed, "R2 no frame while busy high", !stayed, 0);
    end
    busyIn = 1'b0;
    for (int t = 0; t < 20 && csN; t++) @(negedge clk);
    chk(!csN, "R2 frame after busy fall", csN, 0);
    for (int t = 0; t < 2000 && !csN; t++) @(negedge clk);
    repeat (12) @(negedge clk);

    for (int v = 0; v < 4; v++) runFrame(VECS[v].dual, VECS[v].seed, 1'b1, 1'b0);

    runFrame(1'b1, 16'h3C3C, 1'b0, 1'b0);   // R7 misaligned frame abandoned
    runFrame(1'b0, 16'h1234, 1'b1, 1'b0);   // R7 next frame normal
    runFrame(1'b1, 16'h5AA5, 1'b1, 1'b1);   // R8 R9 disturbance mid-frame
    runFrame(1'b0, 16'hC001, 1'b1, 1'b1);   // R8 R9 disturbance mid-frame

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule